// File: doc/BRIEF.md
# Protection Entry Configuration Registers

This block stores the per-entry settings of a physical memory protection unit: one 8-bit configuration byte and one XLEN-wide address register for each of `N_ENTRIES` entries. Software reaches these through a single-cycle register port that carries a valid strobe, a write enable, a select between the configuration bank and the address bank, a register index and write data. Configuration bytes are packed several to a register word, so one access reads or writes a group of neighbouring entries at once. Read data comes back in the same cycle.

Writes obey lock rules. An entry with its lock bit set refuses every write to its byte and to its address. An entry is also frozen when the entry just above it is locked and uses top-of-range matching, because that upper entry takes its lower bound from this entry's address. Each byte of a packed configuration write is checked on its own, so one word can be partly accepted. Writes that aim at entries that do not exist are dropped. When any part of a write is dropped, a status pulse lasts one cycle. On a 64-bit build, a configuration write to an odd register index is refused as a whole.

After each accepted write the block recounts the entries whose match mode is not OFF and presents that number. All configuration bytes and addresses are also exported flat, for the address-matching logic that follows.

Top module: `prot_entry_regs`

## Requirements
- R1: After reset every configuration byte, every address register, the active count and the ignore pulse are zero.
- R2: An address write (select = 1) to an index below `N_ENTRIES` of an unlocked entry stores the data, and a read of that index returns it.
- R3: Configuration register k holds the byte of entry 4k+i in bits [8i+7:8i]. Writes unpack and reads repack in that order. In each byte, bit 7 is the lock bit and bits [4:3] are the match mode: 0 OFF, 1 top-of-range, 2 four-byte, 3 power-of-two.
- R4: An entry whose own lock bit is set ignores configuration and address writes.
- R5: Entry e is also locked when entry e+1 has its lock bit set and match mode 1. Any other mode on e+1 leaves e writable. The highest entry depends only on its own lock bit.
- R6: In a configuration write, each byte is checked for lock on its own. Bytes for unlocked entries are stored even when other bytes of the same word are dropped.
- R7: Address writes to an index at or above `N_ENTRIES`, and configuration bytes aimed at entries that do not exist, are dropped. Reads of such entries return zero.
- R8: `write_ignored` is high for exactly the one cycle after the clock edge that takes a write with any dropped part, and low otherwise.
- R9: `active_count` equals the number of entries whose match mode is not 0. It is updated in the cycle after an accepted write.
- R10: `csr_rdata` is combinational for a valid read (valid = 1, write enable = 0) and zero at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_valid | input | 1 | Access strobe, one cycle per access |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_sel | input | 1 | 0 = configuration bank, 1 = address bank |
| csr_index | input | IDX_W | Register index within the selected bank |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, same cycle |
| write_ignored | output | 1 | One-cycle pulse after a write with a dropped part |
| active_count | output | CNT_W | Number of entries not in mode OFF |
| entry_cfg | output | 8*N_ENTRIES | All configuration bytes, entry e at [8e+7:8e] |
| entry_addr | output | XLEN*N_ENTRIES | All address registers, entry e at [XLEN*e+XLEN-1:XLEN*e] |

## Verification
Read data is due in the same cycle as the request. The bench checks it 1 ns after driving the inputs, before any clock edge. Stored bytes, addresses, `active_count` and `write_ignored` change at the edge that takes a write. The bench checks them at the falling edge that follows, having dropped the strobe just after the rising edge, so each access is taken exactly once. The reference model works out all lock decisions from the state before the write. This is how the partly accepted words and the neighbour locks are predicted, and a further idle cycle confirms that the ignore pulse has ended.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_NA4   = 2'd2,
    MATCH_NAPOT = 2'd3
  } match_mode_e;

  localparam int LOCK_POS = 7;
  localparam int MODE_LSB = 3;
  localparam logic SEL_CFG  = 1'b0;
  localparam logic SEL_ADDR = 1'b1;

  function automatic match_mode_e mode_of(input logic [7:0] c);
    return match_mode_e'(c[MODE_LSB +: 2]);
  endfunction

  function automatic logic lock_of(input logic [7:0] c);
    return c[LOCK_POS];
  endfunction
endpackage

// File: rtl/prot_lock_eval.sv
module prot_lock_eval
  import prot_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic [N_ENTRIES-1:0][7:0] cfg,
  output logic [N_ENTRIES-1:0]      locked
);
  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_lock
    if (e == N_ENTRIES - 1) begin : g_top
      assign locked[e] = lock_of(cfg[e]);
    end else begin : g_mid
      assign locked[e] = lock_of(cfg[e]) |
                         (lock_of(cfg[e+1]) & (mode_of(cfg[e+1]) == MATCH_TOR));
    end
  end
endmodule

// File: rtl/prot_write_ctl.sv
module prot_write_ctl
  import prot_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int XLEN      = 32,
  parameter int IDX_W     = 8
) (
  input  logic                      csr_valid,
  input  logic                      csr_we,
  input  logic                      csr_sel,
  input  logic [IDX_W-1:0]          csr_index,
  input  logic [XLEN-1:0]           csr_wdata,
  input  logic [N_ENTRIES-1:0]      locked,
  output logic [N_ENTRIES-1:0]      cfg_wr_en,
  output logic [N_ENTRIES-1:0][7:0] cfg_new,
  output logic [N_ENTRIES-1:0]      addr_wr_en,
  output logic                      drop
);
  localparam int  BYTES     = XLEN / 8;
  localparam int  TW        = IDX_W + 3;
  localparam int  EW        = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam bit  ODD_GUARD = (XLEN == 64);

  logic          cfg_hit, addr_hit, odd_bad;
  logic [TW-1:0] base, tgt;

  always_comb begin
    cfg_hit    = csr_valid && csr_we && (csr_sel == SEL_CFG);
    addr_hit   = csr_valid && csr_we && (csr_sel == SEL_ADDR);
    odd_bad    = ODD_GUARD && csr_index[0];
    base       = {1'b0, csr_index, 2'b00};
    tgt        = '0;
    drop       = 1'b0;
    cfg_wr_en  = '0;
    cfg_new    = '0;
    addr_wr_en = '0;

    if (cfg_hit) begin
      if (odd_bad) begin
        drop = 1'b1;
      end else begin
        for (int i = 0; i < BYTES; i++) begin
          tgt = base + TW'(i);
          if (tgt < TW'(N_ENTRIES)) begin
            if (locked[tgt[EW-1:0]]) begin
              drop = 1'b1;
            end else begin
              cfg_wr_en[tgt[EW-1:0]] = 1'b1;
              cfg_new[tgt[EW-1:0]]   = csr_wdata[8*i +: 8];
            end
          end else begin
            drop = 1'b1;
          end
        end
      end
    end

    if (addr_hit) begin
      if ({1'b0, csr_index} < (IDX_W+1)'(N_ENTRIES)) begin
        if (locked[csr_index[EW-1:0]]) drop = 1'b1;
        else addr_wr_en[csr_index[EW-1:0]] = 1'b1;
      end else begin
        drop = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prot_read_mux.sv
module prot_read_mux
  import prot_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int XLEN      = 32,
  parameter int IDX_W     = 8
) (
  input  logic                         csr_valid,
  input  logic                         csr_we,
  input  logic                         csr_sel,
  input  logic [IDX_W-1:0]             csr_index,
  input  logic [N_ENTRIES-1:0][7:0]    cfg,
  input  logic [N_ENTRIES-1:0][XLEN-1:0] addr,
  output logic [XLEN-1:0]              rdata
);
  localparam int BYTES = XLEN / 8;
  localparam int TW    = IDX_W + 3;
  localparam int EW    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic [TW-1:0] base, tgt;

  always_comb begin
    rdata = '0;
    base  = {1'b0, csr_index, 2'b00};
    tgt   = '0;
    if (csr_valid && !csr_we) begin
      if (csr_sel == SEL_CFG) begin
        for (int i = 0; i < BYTES; i++) begin
          tgt = base + TW'(i);
          if (tgt < TW'(N_ENTRIES)) rdata[8*i +: 8] = cfg[tgt[EW-1:0]];
        end
      end else if ({1'b0, csr_index} < (IDX_W+1)'(N_ENTRIES)) begin
        rdata = addr[csr_index[EW-1:0]];
      end
    end
  end
endmodule

// File: rtl/prot_active_count.sv
module prot_active_count
  import prot_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int CNT_W     = $clog2(N_ENTRIES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd_en,
  input  logic [N_ENTRIES-1:0][7:0] cfg_next,
  output logic [CNT_W-1:0]          count
);
  logic [CNT_W-1:0] count_d, count_q;

  always_comb begin
    count_d = count_q;
    if (upd_en) begin
      count_d = '0;
      for (int e = 0; e < N_ENTRIES; e++) begin
        if (mode_of(cfg_next[e]) != MATCH_OFF) count_d = count_d + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(N_ENTRIES))
    else $error("active count above entry total");

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(count_q))
    else $error("active count moved without an accepted write");
endmodule

// File: rtl/prot_entry_regs.sv
module prot_entry_regs
  import prot_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int XLEN      = 32,
  parameter int IDX_W     = 8,
  parameter int CNT_W     = $clog2(N_ENTRIES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      csr_valid,
  input  logic                      csr_we,
  input  logic                      csr_sel,
  input  logic [IDX_W-1:0]          csr_index,
  input  logic [XLEN-1:0]           csr_wdata,
  output logic [XLEN-1:0]           csr_rdata,
  output logic                      write_ignored,
  output logic [CNT_W-1:0]          active_count,
  output logic [8*N_ENTRIES-1:0]    entry_cfg,
  output logic [XLEN*N_ENTRIES-1:0] entry_addr
);
  logic [N_ENTRIES-1:0][7:0]      cfg_q, cfg_d, cfg_new;
  logic [N_ENTRIES-1:0][XLEN-1:0] addr_q, addr_d;
  logic [N_ENTRIES-1:0]           lock_vec, cfg_wr_en, addr_wr_en;
  logic                           drop, ign_q;

  prot_lock_eval #(.N_ENTRIES(N_ENTRIES)) u_lock (
    .cfg    (cfg_q),
    .locked (lock_vec)
  );

  prot_write_ctl #(.N_ENTRIES(N_ENTRIES), .XLEN(XLEN), .IDX_W(IDX_W)) u_wctl (
    .csr_valid  (csr_valid),
    .csr_we     (csr_we),
    .csr_sel    (csr_sel),
    .csr_index  (csr_index),
    .csr_wdata  (csr_wdata),
    .locked     (lock_vec),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_new    (cfg_new),
    .addr_wr_en (addr_wr_en),
    .drop       (drop)
  );

  prot_read_mux #(.N_ENTRIES(N_ENTRIES), .XLEN(XLEN), .IDX_W(IDX_W)) u_rmux (
    .csr_valid (csr_valid),
    .csr_we    (csr_we),
    .csr_sel   (csr_sel),
    .csr_index (csr_index),
    .cfg       (cfg_q),
    .addr      (addr_q),
    .rdata     (csr_rdata)
  );

  prot_active_count #(.N_ENTRIES(N_ENTRIES), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (|cfg_wr_en),
    .cfg_next (cfg_d),
    .count    (active_count)
  );

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    always_comb begin
      cfg_d[e]  = cfg_wr_en[e]  ? cfg_new[e] : cfg_q[e];
      addr_d[e] = addr_wr_en[e] ? csr_wdata  : addr_q[e];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[e]  <= '0;
        addr_q[e] <= '0;
      end else begin
        if (cfg_wr_en[e])  cfg_q[e]  <= cfg_d[e];
        if (addr_wr_en[e]) addr_q[e] <= addr_d[e];
      end
    end

    assert_lock_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lock_of(cfg_q[e]) |=> $stable(addr_q[e]))
      else $error("locked entry address changed");

    assert_lock_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lock_of(cfg_q[e]) |=> $stable(cfg_q[e]))
      else $error("locked entry byte changed");

    if (e < N_ENTRIES - 1) begin : g_nb
      assert_tor_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_of(cfg_q[e+1]) && mode_of(cfg_q[e+1]) == MATCH_TOR)
          |=> ($stable(addr_q[e]) && $stable(cfg_q[e])))
        else $error("entry below a locked top-of-range entry changed");
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ign_q <= 1'b0;
    else        ign_q <= drop;
  end

  assign write_ignored = ign_q;
  assign entry_cfg     = cfg_q;
  assign entry_addr    = addr_q;

  assert_ignore_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(csr_valid && csr_we) |-> !write_ignored)
    else $error("ignore pulse without a write");
endmodule

// File: tb/prot_entry_regs_tb.sv
`timescale 1ns/1ps
module prot_entry_regs_tb;
  localparam int N   = 16;
  localparam int XL  = 32;
  localparam int IW  = 8;
  localparam int CW  = $clog2(N + 1);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            csr_valid, csr_we, csr_sel;
  logic [IW-1:0]   csr_index;
  logic [XL-1:0]   csr_wdata, csr_rdata;
  logic            write_ignored;
  logic [CW-1:0]   active_count;
  logic [8*N-1:0]  entry_cfg;
  logic [XL*N-1:0] entry_addr;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0]    m_cfg  [N];
  logic [XL-1:0] m_addr [N];

  always #10 clk = ~clk;

  prot_entry_regs #(.N_ENTRIES(N), .XLEN(XL), .IDX_W(IW)) u_dut (
    .clk (clk), .rst_n (rst_n), .csr_valid (csr_valid), .csr_we (csr_we),
    .csr_sel (csr_sel), .csr_index (csr_index), .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata), .write_ignored (write_ignored),
    .active_count (active_count), .entry_cfg (entry_cfg), .entry_addr (entry_addr)
  );

  task automatic check(input string req, input logic [511:0] got, input logic [511:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic bit m_locked(input int e);
    if (m_cfg[e][7]) return 1;
    if (e + 1 < N && m_cfg[e+1][7] && m_cfg[e+1][4:3] == 2'd1) return 1;
    return 0;
  endfunction

  function automatic logic [XL-1:0] m_read(input logic sel, input int idx);
    logic [XL-1:0] r = '0;
    if (sel == 1'b0) begin
      for (int i = 0; i < XL/8; i++) if (idx*4 + i < N) r[8*i +: 8] = m_cfg[idx*4 + i];
    end else if (idx < N) r = m_addr[idx];
    return r;
  endfunction

  function automatic logic [8*N-1:0] m_cfg_flat();
    logic [8*N-1:0] f;
    for (int e = 0; e < N; e++) f[8*e +: 8] = m_cfg[e];
    return f;
  endfunction

  function automatic logic [XL*N-1:0] m_addr_flat();
    logic [XL*N-1:0] f;
    for (int e = 0; e < N; e++) f[XL*e +: XL] = m_addr[e];
    return f;
  endfunction

  function automatic int m_count();
    int c = 0;
    for (int e = 0; e < N; e++) if (m_cfg[e][4:3] != 2'd0) c++;
    return c;
  endfunction

  task automatic op(input logic we, input logic sel, input int idx,
                    input logic [XL-1:0] data, input string req);
    bit lk [N];
    bit exp_ign = 0;
    @(negedge clk);
    csr_valid = 1'b1; csr_we = we; csr_sel = sel;
    csr_index = IW'(idx); csr_wdata = data;
    #1;
    check({req, " R10 rdata"}, 512'(csr_rdata), 512'(we ? '0 : m_read(sel, idx)));
    if (we) begin
      for (int e = 0; e < N; e++) lk[e] = m_locked(e);
      if (sel == 1'b0) begin
        for (int i = 0; i < XL/8; i++) begin
          int t = idx*4 + i;
          if (t >= N || lk[t]) exp_ign = 1;
          else m_cfg[t] = data[8*i +: 8];
        end
      end else begin
        if (idx >= N || lk[idx]) exp_ign = 1;
        else m_addr[idx] = data;
      end
    end
    @(posedge clk); #1;
    csr_valid = 1'b0; csr_we = 1'b0;
    @(negedge clk);
    check({req, " R8 ignore pulse"}, 512'(write_ignored), 512'(exp_ign));
    check({req, " R9 count"}, 512'(active_count), 512'(m_count()));
    check({req, " cfg state"}, 512'(entry_cfg), 512'(m_cfg_flat()));
    check({req, " addr state"}, 512'(entry_addr), 512'(m_addr_flat()));
  endtask

  initial begin
    #(20.0 * 200000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; csr_valid = 1'b0; csr_we = 1'b0; csr_sel = 1'b0;
    csr_index = '0; csr_wdata = '0;
    for (int e = 0; e < N; e++) begin m_cfg[e] = '0; m_addr[e] = '0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R1 cfg", 512'(entry_cfg), 512'(0));
    check("R1 addr", 512'(entry_addr), 512'(0));
    check("R1 count", 512'(active_count), 512'(0));
    check("R1 ignore", 512'(write_ignored), 512'(0));

    op(1, 1, 3, 32'h0000_1000, "R2 addr write");
    op(0, 1, 3, 32'h0, "R2 addr read");
    op(1, 0, 0, 32'h1808_001F, "R3 cfg pack write");
    op(0, 0, 0, 32'h0, "R3 cfg pack read");
    op(1, 1, 16, 32'hDEAD_BEEF, "R7 addr out of range");
    op(0, 1, 20, 32'h0, "R7 addr read beyond");
    op(1, 0, 4, 32'hFFFF_FFFF, "R7 cfg beyond");
    op(0, 0, 4, 32'h0, "R7 cfg read beyond");
    op(1, 0, 1, 32'h0000_8800, "R4 set lock tor");
    op(1, 1, 5, 32'h0000_ABCD, "R4 own lock addr");
    op(1, 0, 1, 32'h1111_1111, "R6 partial cfg word");
    op(0, 0, 1, 32'h0, "R6 partial readback");
    op(1, 1, 4, 32'h0000_0055, "R5 neighbour tor lock");
    op(1, 1, 6, 32'h0000_0066, "R5 above lock free");
    op(1, 0, 2, 32'h0000_9000, "R5 lock non tor");
    op(1, 1, 8, 32'h0000_0088, "R5 below non tor free");
    op(1, 0, 3, 32'h9800_0000, "R5 top entry lock");
    op(1, 1, 15, 32'h0000_00F0, "R5 top entry addr");
    op(1, 1, 14, 32'h0000_00E0, "R5 below top free");

    op(1, 1, 5, 32'h1, "R8 drop again");
    @(negedge clk);
    check("R8 pulse one cycle", 512'(write_ignored), 512'(0));

    csr_valid = 1'b0; csr_we = 1'b0; csr_sel = 1'b1; csr_index = IW'(3);
    #1;
    check("R10 idle rdata", 512'(csr_rdata), 512'(0));

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule